// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital control core of a dual-slope integrating converter. It steps the external analog section through four phases in turn: zeroing, timed signal integration, reference de-integration, and integrator recovery. In each phase it raises the matching switch enables. It watches one comparator bit that reports the sign of the integrator output. From that bit it latches the input polarity and detects the zero crossing that ends de-integration. The number of de-integrate clocks before the crossing is the reading. With the default timing, an input equal to the reference reads 10000 and full scale is 20000.

Each reading comes with a polarity bit, an overrange flag and an underrange flag, all updated together, and a one-cycle valid strobe. A busy output frames the integrate and de-integrate phases. A run/hold input lets a host stop conversions: the current conversion is completed, the sequencer then waits in the zeroing phase, and the last reading stays on the outputs. All phase lengths and thresholds are parameters.

Top module: `dsc_sequencer`

## Requirements
- R1: The phases always follow the order zeroing, integrate, de-integrate, recovery, and then zeroing again.
- R2: The enables for each phase are as follows. In zeroing, `sw_short_o` and `sw_azloop_o` are high and `sw_input_o` is low. In integrate, only `sw_input_o` is high. In recovery, only `sw_zero_o` is high.
- R3: Integrate lasts INT_CLKS clocks (default 10000). The comparator is sampled on the last integrate clock and held as the polarity until the next integrate ends. `cmp_i` high means the integrator is positive, and `pol_o` = 1 means positive.
- R4: During de-integrate exactly one reference enable is high. `sw_refn_o` is high when `pol_o` = 1 and `sw_refp_o` is high when `pol_o` = 0.
- R5: The reading is k when `cmp_i` first differs from the held polarity on de-integrate clock k, counting from 0. De-integrate then lasts k+1 clocks.
- R6: If no crossing is seen within DE_MAX clocks (default 20001), `over_o` is set and the reading saturates at DE_MAX-1. A crossing on the last allowed clock gives DE_MAX-1 with `over_o` low.
- R7: `under_o` is high exactly when a reading with a crossing is below UNDER_TH (default 1800). Both range flags change only when the reading changes.
- R8: Recovery lasts ZI_NORM clocks (default 150), or ZI_OVR clocks (default 6200) after an overrange reading.
- R9: Zeroing lasts AZ_CLKS clocks while `run_i` is high.
- R10: `busy_o` is high exactly during integrate and de-integrate.
- R11: `valid_o` is high for only the first recovery clock, and during that clock the new reading and flags are on the outputs.
- R12: While `run_i` is low, the current conversion finishes and the block stays in zeroing with the reading held. Integrate starts on the first clock after `run_i` is seen high again, provided zeroing has run its full length.
- R13: Reset puts the block in zeroing with the reading at 0, `pol_o` at 1 and both range flags and `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_i | input | 1 | High: keep converting; low: park in zeroing after the current conversion |
| cmp_i | input | 1 | Comparator, high when the integrator output is positive |
| sw_short_o | output | 1 | Short the inputs to common (zeroing) |
| sw_azloop_o | output | 1 | Close the offset-storage loop (zeroing) |
| sw_input_o | output | 1 | Connect the differential input (integrate) |
| sw_refp_o | output | 1 | Apply the reference with positive sense (de-integrate) |
| sw_refn_o | output | 1 | Apply the reference with negative sense (de-integrate) |
| sw_zero_o | output | 1 | Close the integrator recovery loop |
| busy_o | output | 1 | Integrate or de-integrate in progress |
| pol_o | output | 1 | Held polarity, 1 = positive |
| count_o | output | $clog2(DE_MAX) | Reading magnitude |
| over_o | output | 1 | Reading saturated, no crossing seen |
| under_o | output | 1 | Reading below the underrange threshold |
| valid_o | output | 1 | One-cycle strobe marking a new reading |

## Verification
The bench drives the comparator from a model that flips it a chosen number of de-integrate clocks after the phase starts. It targets readings of zero, readings just below and at the underrange threshold, a crossing on the very last allowed clock, and a run with no crossing. An off-by-one in the crossing count would shift every reading and de-integrate length by one. A wrong saturation bound would misflag the last-clock crossing or return the wrong saturated value. The bench also checks that recovery returns to the short length after an overrange, which a design that kept the flag sticky would miss. It checks that a negative zero reading keeps its sign, and that the reading stays frozen and integrate stays off for hundreds of clocks under hold, then restarts one clock after release.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2,
    PH_ZI  = 2'd3
  } phase_e;

  function automatic phase_e ph_succ(input phase_e p);
    case (p)
      PH_AZ:   return PH_INT;
      PH_INT:  return PH_DE;
      PH_DE:   return PH_ZI;
      default: return PH_AZ;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
  import dsc_pkg::*;
#(
  parameter int AZ_CLKS  = 1000,
  parameter int INT_CLKS = 10000,
  parameter int ZI_NORM  = 150,
  parameter int ZI_OVR   = 6200,
  parameter int TMR_W    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             de_end_i,
  input  logic             over_i,
  output phase_e           phase_o,
  output logic [TMR_W-1:0] tmr_o,
  output logic             int_end_o
);
  localparam logic [TMR_W-1:0] AZ_LAST  = TMR_W'(AZ_CLKS - 1);
  localparam logic [TMR_W-1:0] INT_LAST = TMR_W'(INT_CLKS - 1);
  localparam logic [TMR_W-1:0] ZIN_LAST = TMR_W'(ZI_NORM - 1);
  localparam logic [TMR_W-1:0] ZIO_LAST = TMR_W'(ZI_OVR - 1);

  phase_e           ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             adv;
  logic             az_done;

  assign az_done   = (ph_q == PH_AZ) && (tmr_q >= AZ_LAST);
  assign int_end_o = (ph_q == PH_INT) && (tmr_q == INT_LAST);

  always_comb begin
    adv = 1'b0;
    case (ph_q)
      PH_AZ:   adv = az_done && run_i;
      PH_INT:  adv = int_end_o;
      PH_DE:   adv = de_end_i;
      default: adv = (tmr_q == (over_i ? ZIO_LAST : ZIN_LAST));
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    tmr_d  = tmr_q + 1'b1;
    tmr_en = !az_done;
    if (adv) begin
      ph_d   = ph_succ(ph_q);
      tmr_d  = '0;
      tmr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_AZ;
      tmr_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign phase_o = ph_q;
  assign tmr_o   = tmr_q;

  assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> (ph_q == ph_succ($past(ph_q))));

  assert_int_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_INT && ph_q != PH_INT) |-> ($past(tmr_q) == INT_LAST));

  assert_zi_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_ZI && ph_q == PH_AZ) |->
      ($past(tmr_q) == ($past(over_i) ? ZIO_LAST : ZIN_LAST)));

  assert_az_leave_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_AZ && ph_q == PH_INT) |-> ($past(run_i) && $past(tmr_q) >= AZ_LAST));
endmodule

// File: rtl/dsc_result.sv
module dsc_result
  import dsc_pkg::*;
#(
  parameter int DE_MAX   = 20001,
  parameter int UNDER_TH = 1800,
  parameter int TMR_W    = 15,
  parameter int RD_W     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic             int_end_i,
  input  logic             cmp_i,
  output logic             de_end_o,
  output logic             pol_o,
  output logic [RD_W-1:0]  count_o,
  output logic             over_o,
  output logic             under_o,
  output logic             valid_o
);
  localparam logic [TMR_W-1:0] DE_LAST   = TMR_W'(DE_MAX - 1);
  localparam logic [TMR_W-1:0] UNDER_LIM = TMR_W'(UNDER_TH);
  localparam logic [RD_W-1:0]  RD_SAT    = RD_W'(DE_MAX - 1);

  logic            pol_q, pol_d;
  logic [RD_W-1:0] cnt_q, cnt_d;
  logic            ovr_q, ovr_d, und_q, und_d, vld_q;
  logic            in_de, crossing, timeout;

  assign in_de    = (phase_i == PH_DE);
  assign crossing = in_de && (cmp_i != pol_q);
  assign timeout  = in_de && (tmr_i == DE_LAST);
  assign de_end_o = crossing || timeout;

  always_comb begin
    pol_d = int_end_i ? cmp_i : pol_q;
    cnt_d = crossing ? tmr_i[RD_W-1:0] : RD_SAT;
    ovr_d = !crossing;
    und_d = crossing && (tmr_i < UNDER_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b1;
      cnt_q <= '0;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      pol_q <= pol_d;
      vld_q <= de_end_o;
      if (de_end_o) begin
        cnt_q <= cnt_d;
        ovr_q <= ovr_d;
        und_q <= und_d;
      end
    end
  end

  assign pol_o   = pol_q;
  assign count_o = cnt_q;
  assign over_o  = ovr_q;
  assign under_o = und_q;
  assign valid_o = vld_q;

  assert_pol_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DE) |=> $stable(pol_q));

  assert_de_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_de |-> (tmr_i <= DE_LAST));

  assert_sat_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (cnt_q == RD_SAT && !und_q));

  assert_under_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    und_q |-> (cnt_q < RD_W'(UNDER_TH)));

  assert_flags_with_reading_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ($stable(cnt_q) && $stable(ovr_q) && $stable(und_q)));

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int AZ_CLKS  = 1000,
  parameter int INT_CLKS = 10000,
  parameter int DE_MAX   = 20001,
  parameter int UNDER_TH = 1800,
  parameter int ZI_NORM  = 150,
  parameter int ZI_OVR   = 6200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_i,
  input  logic                       cmp_i,
  output logic                       sw_short_o,
  output logic                       sw_azloop_o,
  output logic                       sw_input_o,
  output logic                       sw_refp_o,
  output logic                       sw_refn_o,
  output logic                       sw_zero_o,
  output logic                       busy_o,
  output logic                       pol_o,
  output logic [$clog2(DE_MAX)-1:0]  count_o,
  output logic                       over_o,
  output logic                       under_o,
  output logic                       valid_o
);
  localparam int TMR_W = $clog2(max4(AZ_CLKS, INT_CLKS, DE_MAX, ZI_OVR) + 1);
  localparam int RD_W  = $clog2(DE_MAX);

  logic             rst_n_sync;
  phase_e           phase;
  logic [TMR_W-1:0] tmr;
  logic             int_end, de_end;

  dsc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dsc_phase_ctrl #(
    .AZ_CLKS  (AZ_CLKS),
    .INT_CLKS (INT_CLKS),
    .ZI_NORM  (ZI_NORM),
    .ZI_OVR   (ZI_OVR),
    .TMR_W    (TMR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .run_i     (run_i),
    .de_end_i  (de_end),
    .over_i    (over_o),
    .phase_o   (phase),
    .tmr_o     (tmr),
    .int_end_o (int_end)
  );

  dsc_result #(
    .DE_MAX   (DE_MAX),
    .UNDER_TH (UNDER_TH),
    .TMR_W    (TMR_W),
    .RD_W     (RD_W)
  ) u_res (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .phase_i   (phase),
    .tmr_i     (tmr),
    .int_end_i (int_end),
    .cmp_i     (cmp_i),
    .de_end_o  (de_end),
    .pol_o     (pol_o),
    .count_o   (count_o),
    .over_o    (over_o),
    .under_o   (under_o),
    .valid_o   (valid_o)
  );

  always_comb begin
    sw_short_o  = (phase == PH_AZ);
    sw_azloop_o = (phase == PH_AZ);
    sw_input_o  = (phase == PH_INT);
    sw_refp_o   = (phase == PH_DE) && !pol_o;
    sw_refn_o   = (phase == PH_DE) && pol_o;
    sw_zero_o   = (phase == PH_ZI);
    busy_o      = (phase == PH_INT) || (phase == PH_DE);
  end

  assert_ref_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy_o && !sw_input_o |-> $onehot({sw_refp_o, sw_refn_o}));

  assert_ref_sense_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    sw_refn_o |-> pol_o);

  assert_busy_frame_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy_o |-> !(sw_short_o || sw_zero_o));

  assert_valid_in_zi_R11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    valid_o |-> sw_zero_o);
endmodule

// File: tb/dsc_sequencer_test.sv
module dsc_sequencer_test;
  localparam int B_AZ  = 20;
  localparam int B_INT = 100;
  localparam int B_DE  = 201;
  localparam int B_UND = 18;
  localparam int B_ZN  = 15;
  localparam int B_ZOV = 62;
  localparam int RDW   = $clog2(B_DE);

  logic clk = 1'b0;
  logic rst_n, run_i, cmp_i;
  logic sw_short_o, sw_azloop_o, sw_input_o, sw_refp_o, sw_refn_o, sw_zero_o;
  logic busy_o, pol_o, over_o, under_o, valid_o;
  logic [RDW-1:0] count_o;

  int checks = 0;
  int errors = 0;
  bit sgn = 1'b1;
  int target = 0;
  int de_seen = 0;

  always #5 clk = ~clk;

  dsc_sequencer #(
    .AZ_CLKS (B_AZ), .INT_CLKS (B_INT), .DE_MAX (B_DE),
    .UNDER_TH (B_UND), .ZI_NORM (B_ZN), .ZI_OVR (B_ZOV)
  ) uut (
    .clk (clk), .rst_n (rst_n), .run_i (run_i), .cmp_i (cmp_i),
    .sw_short_o (sw_short_o), .sw_azloop_o (sw_azloop_o), .sw_input_o (sw_input_o),
    .sw_refp_o (sw_refp_o), .sw_refn_o (sw_refn_o), .sw_zero_o (sw_zero_o),
    .busy_o (busy_o), .pol_o (pol_o), .count_o (count_o),
    .over_o (over_o), .under_o (under_o), .valid_o (valid_o)
  );

  // Comparator model: holds the input sign, flips `target` de-integrate clocks in.
  always @(negedge clk) begin
    if (sw_refp_o || sw_refn_o) begin
      cmp_i   <= (de_seen >= target) ? ~sgn : sgn;
      de_seen <= de_seen + 1;
    end else begin
      cmp_i   <= sgn;
      de_seen <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; run_i = 1'b1; cmp_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 zeroing after reset", {sw_short_o, sw_azloop_o, sw_input_o}, 3'b110);
    chk("R13 reading cleared", count_o, 0);
    chk("R13 polarity positive", pol_o, 1);
    chk("R13 flags low", {over_o, under_o, valid_o, busy_o}, 0);
    rst_n = 1'b1;
  endtask

  // One full conversion with sign s and crossing after n de-integrate clocks.
  task automatic conv(input bit s, input int n, input string tag);
    int nint, nde, np, nn, nzi, naz, busy_bad, v2;
    bit exp_over, exp_under;
    int exp_rd;
    exp_over  = (n > B_DE - 1);
    exp_rd    = exp_over ? B_DE - 1 : n;
    exp_under = !exp_over && (exp_rd < B_UND);
    sgn = s; target = n;
    while (!sw_input_o) @(negedge clk);
    nint = 0; busy_bad = 0;
    while (sw_input_o) begin
      if (!busy_o || sw_short_o) busy_bad++;
      nint++; @(negedge clk);
    end
    chk({"R3 integrate length ", tag}, nint, B_INT);
    chk({"R1 de-integrate follows integrate ", tag}, sw_refp_o | sw_refn_o, 1);
    nde = 0; np = 0; nn = 0;
    while (sw_refp_o || sw_refn_o) begin
      if (!busy_o) busy_bad++;
      np += int'(sw_refp_o); nn += int'(sw_refn_o);
      nde++; @(negedge clk);
    end
    chk({"R5 de-integrate length ", tag}, nde, exp_over ? B_DE : n + 1);
    chk({"R4 negative-sense clocks ", tag}, nn, s ? nde : 0);
    chk({"R4 positive-sense clocks ", tag}, np, s ? 0 : nde);
    chk({"R1 recovery follows ", tag}, sw_zero_o, 1);
    chk({"R10 busy frame ", tag}, busy_bad + int'(busy_o), 0);
    chk({"R11 valid in first recovery clock ", tag}, valid_o, 1);
    chk({"R5 reading ", tag}, count_o, exp_rd);
    chk({"R6 overrange ", tag}, over_o, exp_over);
    chk({"R7 underrange ", tag}, under_o, exp_under);
    chk({"R3 polarity ", tag}, pol_o, s);
    nzi = 0; v2 = 0;
    while (sw_zero_o) begin
      if (nzi == 1) v2 = valid_o;
      if (nzi > 0 && (sw_short_o || sw_input_o)) busy_bad++;
      nzi++; @(negedge clk);
    end
    chk({"R11 valid single cycle ", tag}, v2, 0);
    chk({"R8 recovery length ", tag}, nzi, exp_over ? B_ZOV : B_ZN);
    chk({"R2 zeroing switches ", tag}, {sw_short_o, sw_azloop_o, sw_input_o, busy_o}, 4'b1100);
    naz = 0;
    while (sw_short_o) begin naz++; @(negedge clk); end
    chk({"R9 zeroing length ", tag}, naz, B_AZ);
    chk({"R2 integrate switches ", tag},
        {sw_short_o, sw_azloop_o, sw_input_o, sw_refp_o, sw_refn_o, sw_zero_o}, 6'b001000);
  endtask

  // Run/hold: drop run during integrate, check parking and held reading.
  task automatic test_hold();
    int bad;
    sgn = 1'b1; target = 40; run_i = 1'b0;
    while (!sw_zero_o) @(negedge clk);
    while (sw_zero_o) @(negedge clk);
    bad = 0;
    repeat (300) begin
      if (!sw_short_o || sw_input_o || busy_o || valid_o || count_o != 40) bad++;
      @(negedge clk);
    end
    chk("R12 parked in zeroing", bad, 0);
    chk("R12 reading held", count_o, 40);
    run_i = 1'b1;
    @(negedge clk);
    chk("R12 integrate one clock after release", sw_input_o, 1);
  endtask

  initial begin
    test_reset();
    conv(1'b1, 100, "mid-scale positive");
    conv(1'b0, 57, "negative input");
    conv(1'b1, 0, "positive zero");
    conv(1'b0, 0, "negative zero");
    conv(1'b1, B_UND - 1, "below underrange");
    conv(1'b1, B_UND, "at underrange threshold");
    conv(1'b1, B_DE - 1, "crossing on last clock");
    conv(1'b0, 500, "no crossing");
    conv(1'b1, 30, "after overrange");
    test_hold();
    conv(1'b1, 77, "after hold");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule